// File: doc/BRIEF.md
# Raster Interrupt Counter with A12 Edge Filter

This block raises a level interrupt request for a cartridge bank controller after a chosen number of video scanlines or fixed-period intervals. The CPU writes four registers: an 8-bit reload value, a mode register, an acknowledge/disable strobe and an arm strobe. An 8-bit down-counter runs from the reload value. The interrupt fires when a decrement reaches zero while the block is armed.

The counter is not clocked directly. A delay countdown, driven by a per-dot tick, stands between the trigger and the counter. In scanline mode (mode bit 0) the trigger is a rising edge of video address bit 12. An edge is honoured only when the line has been quiet for 15 ticks. Every edge restarts that quiet window, and an honoured edge clocks the counter 11 ticks later. In interval mode (mode bit 1) the countdown reloads itself, so the counter is clocked once every 12 ticks.

Top module: `raster_irq_unit`

## Requirements
- R1: After reset, `irq` is 0, and the counter, reload value, quiet window, countdown, mode bit, arm flag and reload-pending flag are all 0.
- R2: A write with `wr_sel`=0 stores `wr_data` as the 8-bit reload value.
- R3: A write with `wr_sel`=1 takes `wr_data[0]` as the mode bit and sets the reload-pending flag. When `wr_data[0]` is 1, the write also presets the delay countdown to 12.
- R4: A write with `wr_sel`=2 clears the arm flag and the pending interrupt, so `irq` is 0 in the next cycle. A write with `wr_sel`=3 sets the arm flag.
- R5: Each counter clock does the first of these that applies. If reload is pending, load reload+1 (up to 256) and clear the pending flag. If the counter is 0, load the reload value. Otherwise decrement; if the result is 0 and the block is armed, set the pending interrupt.
- R6: Each rising edge of `vaddr_a12` restarts the quiet window at 15. The edge loads the countdown with 11 only if the quiet window was already 0. Edges inside the window are otherwise ignored.
- R7: Each `dot_tick` decrements the quiet window and the countdown while each is above 0. The tick that takes the countdown from 1 to 0 clocks the counter. In scanline mode this is the 11th tick after an honoured edge.
- R8: In interval mode, an expiring countdown reloads to 12, so the counter is clocked every 12 ticks.
- R9: `irq` is the pending-interrupt register. It stays 1 until an acknowledge write.
- R10: A register write and a counter clock in the same cycle are resolved write first: the clock sees the new reload value, arm flag and pending flags.
- R11: With a reload value of 0, the counter stays at 0 after an interrupt, and no further interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 reload, 1 mode, 2 acknowledge/disable, 3 arm |
| wr_data | input | 8 | Write data |
| vaddr_a12 | input | 1 | Video address bit 12 |
| dot_tick | input | 1 | One-cycle tick per video dot |
| irq | output | 1 | Level interrupt request, active high |

## Verification
Interval mode is swept over reload values 0 to 7. Each run checks that the interrupt appears exactly at tick (R+2)*12 and not one tick earlier, which separates the reload+1 first load from a plain reload or an off-by-one prescaler. Scanline mode is swept with well-spaced A12 pulses, and the 11-tick delay is checked to the tick. Further patterns cover edge bursts inside the quiet window and a window restarted by an ignored edge, which tells a filter that refreshes from one that only times the first edge. Writes landing on the same cycle as a counter clock, the re-arm period and a zero reload value cover the ordering rules.

// File: rtl/rif_pkg.sv
package rif_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_ACK    = 2'd2,
    SEL_ARM    = 2'd3
  } rif_sel_e;
endpackage

// File: rtl/rif_edge_filter.sv
module rif_edge_filter #(
  parameter int SEP_TICKS = 15,
  localparam int SEP_W = $clog2(SEP_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a12,
  input  logic             tick,
  output logic             a12_rise,
  output logic             edge_take,
  output logic [SEP_W-1:0] sep_q
);
  localparam logic [SEP_W-1:0] SEP_V = SEP_W'(SEP_TICKS);

  logic             a12_q;
  logic [SEP_W-1:0] sep_base;

  assign a12_rise  = a12 & ~a12_q;
  assign edge_take = a12_rise && (sep_q == '0);
  assign sep_base  = a12_rise ? SEP_V : sep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a12_q <= 1'b0;
      sep_q <= '0;
    end else begin
      a12_q <= a12;
      if (tick && sep_base != '0) sep_q <= sep_base - SEP_W'(1);
      else                        sep_q <= sep_base;
    end
  end
endmodule

// File: rtl/rif_countdown.sv
module rif_countdown #(
  parameter int EDGE_DELAY = 11,
  parameter int PERIOD     = 12,
  localparam int CD_MAX = (EDGE_DELAY > PERIOD) ? EDGE_DELAY : PERIOD,
  localparam int CD_W   = $clog2(CD_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            edge_take,
  input  logic            preset,
  input  logic            mode_eff,
  output logic            cnt_clk,
  output logic [CD_W-1:0] cd_q
);
  localparam logic [CD_W-1:0] DELAY_V  = CD_W'(EDGE_DELAY);
  localparam logic [CD_W-1:0] PERIOD_V = CD_W'(PERIOD);

  logic [CD_W-1:0] cd_base;

  // Writes take priority, then an accepted edge, then the tick.
  assign cd_base = preset ? PERIOD_V : (edge_take ? DELAY_V : cd_q);
  assign cnt_clk = tick && (cd_base == CD_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd_q <= '0;
    end else if (tick && cd_base != '0) begin
      if (cd_base == CD_W'(1)) cd_q <= mode_eff ? PERIOD_V : '0;
      else                     cd_q <= cd_base - CD_W'(1);
    end else begin
      cd_q <= cd_base;
    end
  end
endmodule

// File: rtl/rif_counter.sv
module rif_counter
  import rif_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CW = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnt_clk,
  output logic              mode_eff,
  output logic              preset,
  output logic              en_q,
  output logic              irq_q
);
  logic              wr_rld, wr_mode, wr_ack, wr_arm;
  logic [DATA_W-1:0] rld_q, rld_eff;
  logic [CW-1:0]     cnt_q;
  logic              mode_q, rpend_q, rpend_eff, en_eff, irq_eff, fire;

  function automatic logic [CW-1:0] step_cnt(input logic [CW-1:0] cur,
                                             input logic [DATA_W-1:0] rld,
                                             input logic rp);
    if (rp)             return CW'(rld) + CW'(1);
    else if (cur == '0) return CW'(rld);
    else                return cur - CW'(1);
  endfunction

  assign wr_rld  = wr_en && (wr_sel == SEL_RELOAD);
  assign wr_mode = wr_en && (wr_sel == SEL_MODE);
  assign wr_ack  = wr_en && (wr_sel == SEL_ACK);
  assign wr_arm  = wr_en && (wr_sel == SEL_ARM);

  assign rld_eff   = wr_rld ? wr_data : rld_q;
  assign mode_eff  = wr_mode ? wr_data[0] : mode_q;
  assign preset    = wr_mode && wr_data[0];
  assign rpend_eff = wr_mode | rpend_q;
  assign en_eff    = wr_ack ? 1'b0 : (wr_arm | en_q);
  assign irq_eff   = wr_ack ? 1'b0 : irq_q;
  assign fire      = cnt_clk && !rpend_eff && (cnt_q == CW'(1)) && en_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_q   <= '0;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      rpend_q <= 1'b0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      rld_q  <= rld_eff;
      mode_q <= mode_eff;
      en_q   <= en_eff;
      irq_q  <= irq_eff | fire;
      if (cnt_clk) begin
        cnt_q   <= step_cnt(cnt_q, rld_eff, rpend_eff);
        rpend_q <= 1'b0;
      end else begin
        rpend_q <= rpend_eff;
      end
    end
  end
endmodule

// File: rtl/raster_irq_unit.sv
module raster_irq_unit #(
  parameter int DATA_W     = 8,
  parameter int SEP_TICKS  = 15,
  parameter int EDGE_DELAY = 11,
  parameter int PERIOD     = 12,
  localparam int SEP_W  = $clog2(SEP_TICKS + 1),
  localparam int CD_MAX = (EDGE_DELAY > PERIOD) ? EDGE_DELAY : PERIOD,
  localparam int CD_W   = $clog2(CD_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vaddr_a12,
  input  logic              dot_tick,
  output logic              irq
);
  logic             a12_rise, edge_take, cnt_clk, mode_eff, preset, en_q;
  logic [SEP_W-1:0] sep_q;
  logic [CD_W-1:0]  cd_q;

  rif_edge_filter #(.SEP_TICKS(SEP_TICKS)) u_filter (
    .clk(clk), .rst_n(rst_n), .a12(vaddr_a12), .tick(dot_tick),
    .a12_rise(a12_rise), .edge_take(edge_take), .sep_q(sep_q)
  );

  rif_countdown #(.EDGE_DELAY(EDGE_DELAY), .PERIOD(PERIOD)) u_countdown (
    .clk(clk), .rst_n(rst_n), .tick(dot_tick), .edge_take(edge_take),
    .preset(preset), .mode_eff(mode_eff), .cnt_clk(cnt_clk), .cd_q(cd_q)
  );

  rif_counter #(.DATA_W(DATA_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt_clk(cnt_clk), .mode_eff(mode_eff),
    .preset(preset), .en_q(en_q), .irq_q(irq)
  );
endmodule

// File: rtl/rif_checker.sv
module rif_checker
  import rif_pkg::*;
#(
  parameter int SEP_TICKS = 15,
  parameter int PERIOD    = 12,
  parameter int SEP_W     = 4,
  parameter int CD_W      = 4,
  parameter int CD_MAX    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             dot_tick,
  input logic             a12_rise,
  input logic             preset,
  input logic             cnt_clk,
  input logic             mode_eff,
  input logic             en_q,
  input logic [SEP_W-1:0] sep_q,
  input logic [CD_W-1:0]  cd_q,
  input logic             irq
);
  logic ack_w, arm_w;
  assign ack_w = wr_en && (wr_sel == SEL_ACK);
  assign arm_w = wr_en && (wr_sel == SEL_ARM);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_w |=> !irq);
  a_r5_rise_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt_clk));
  a_r5_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en_q || arm_w));
  a_r6_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (a12_rise && !dot_tick) |=> (sep_q == SEP_W'(SEP_TICKS)));
  a_r6_edge_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (a12_rise && sep_q != '0 && !dot_tick && !preset) |=> $stable(cd_q));
  a_r8_period_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clk && mode_eff) |=> (cd_q == CD_W'(PERIOD)));
  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_w) |=> irq);

  always @(posedge clk) begin
    if (rst_n) begin
      a_r7_cd_range: assert (int'(cd_q) <= CD_MAX);
    end
  end
endmodule

bind raster_irq_unit rif_checker #(
  .SEP_TICKS(SEP_TICKS), .PERIOD(PERIOD), .SEP_W(SEP_W), .CD_W(CD_W),
  .CD_MAX(CD_MAX)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .dot_tick(dot_tick), .a12_rise(a12_rise), .preset(preset),
  .cnt_clk(cnt_clk), .mode_eff(mode_eff), .en_q(en_q), .sep_q(sep_q),
  .cd_q(cd_q), .irq(irq)
);

// File: tb/test_raster_irq_unit.sv
`timescale 1ns/1ps
module test_raster_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       vaddr_a12 = 1'b0;
  logic       dot_tick = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  raster_irq_unit i_raster_irq_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .vaddr_a12(vaddr_a12), .dot_tick(dot_tick), .irq(irq)
  );

  task automatic cyc(input logic we, input logic [1:0] sel,
                     input logic [7:0] d, input logic tk);
    wr_en = we; wr_sel = sel; wr_data = d; dot_tick = tk;
    @(negedge clk);
    wr_en = 1'b0; dot_tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cyc(1'b1, sel, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0, 1'b1);
  endtask

  task automatic pulse();
    vaddr_a12 = 1'b1; cyc(1'b0, 2'd0, 8'd0, 1'b0);
    vaddr_a12 = 1'b0; cyc(1'b0, 2'd0, 8'd0, 1'b0);
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: irq=%0b expected run end", irq);
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq, 1'b0, "R1 reset");
    ticks(40);
    check(irq, 1'b0, "R1 idle after reset");

    // R2 R3 R5 R8: interval mode, irq at tick (R+2)*12
    for (int r = 0; r < 8; r++) begin
      wr(2'd2, 8'd0); wr(2'd0, 8'(r)); wr(2'd1, 8'd1); wr(2'd3, 8'd0);
      ticks((r + 2) * 12 - 1);
      check(irq, 1'b0, "R8 interval not early");
      ticks(1);
      check(irq, 1'b1, "R2 R5 interval fire");
    end

    // R9 hold, R4 ack, then re-arm period (R+1)*12 with R=3
    wr(2'd2, 8'd0); wr(2'd0, 8'd3); wr(2'd1, 8'd1); wr(2'd3, 8'd0);
    ticks(60);
    check(irq, 1'b1, "R5 fire r3");
    ticks(20);
    check(irq, 1'b1, "R9 held");
    wr(2'd2, 8'd0);
    check(irq, 1'b0, "R4 ack clears");
    wr(2'd3, 8'd0);
    ticks(7);   // 20 + 7 = 27 ticks since fire; next clock at 36
    ticks(48 - 27 - 1);
    check(irq, 1'b0, "R5 rearm not early");
    ticks(1);
    check(irq, 1'b1, "R5 rearm period");

    // R11: zero reload, no further interrupt
    wr(2'd2, 8'd0); wr(2'd0, 8'd0); wr(2'd1, 8'd1); wr(2'd3, 8'd0);
    ticks(24);
    check(irq, 1'b1, "R11 first fire");
    wr(2'd2, 8'd0); wr(2'd3, 8'd0);
    ticks(120);
    check(irq, 1'b0, "R11 no repeat");

    // R4: disarmed counter reaching zero stays silent
    wr(2'd2, 8'd0); wr(2'd0, 8'd0); wr(2'd1, 8'd1);
    ticks(30);
    check(irq, 1'b0, "R4 disarmed");

    // R10: arm write on the clock that reaches zero
    wr(2'd2, 8'd0); wr(2'd0, 8'd0); wr(2'd1, 8'd1);
    ticks(23);
    cyc(1'b1, 2'd3, 8'd0, 1'b1);
    check(irq, 1'b1, "R10 arm same cycle");

    // R10: reload write on the clock that consumes reload-pending
    wr(2'd2, 8'd0); wr(2'd0, 8'd9); wr(2'd1, 8'd1); wr(2'd3, 8'd0);
    ticks(11);
    cyc(1'b1, 2'd0, 8'd2, 1'b1);
    ticks(35);
    check(irq, 1'b0, "R10 reload same cycle early");
    ticks(1);
    check(irq, 1'b1, "R10 reload same cycle");

    // drain into scanline mode
    wr(2'd2, 8'd0); wr(2'd1, 8'd0);
    ticks(20);

    // R6 R7: scanline sweep, fire 11 ticks after pulse R+2
    for (int r = 0; r < 5; r++) begin
      wr(2'd2, 8'd0); wr(2'd0, 8'(r)); wr(2'd1, 8'd0); wr(2'd3, 8'd0);
      for (int p = 0; p < r + 1; p++) begin
        pulse(); ticks(16);
      end
      check(irq, 1'b0, "R7 scanline not early");
      pulse(); ticks(10);
      check(irq, 1'b0, "R7 delay tick 10");
      ticks(1);
      check(irq, 1'b1, "R7 delay tick 11");
      ticks(5);
    end

    // R6: quiet-window filtering with R=3 (fires on 5th honoured edge)
    wr(2'd2, 8'd0); wr(2'd0, 8'd3); wr(2'd1, 8'd0); wr(2'd3, 8'd0);
    pulse(); ticks(20);
    pulse(); ticks(4); pulse(); ticks(30);
    check(irq, 1'b0, "R6 burst filtered");
    pulse(); ticks(12); pulse(); ticks(14); pulse(); ticks(16);
    check(irq, 1'b0, "R6 window restarted");
    pulse(); ticks(16);
    check(irq, 1'b0, "R6 fourth clock");
    pulse(); ticks(16);
    check(irq, 1'b1, "R6 fifth clock fires");

    finish_run();
  end
endmodule